// File: doc/BRIEF.md
# Idle Interval Timer

A free-running 16-bit down-counter that advances once per instruction-cycle tick and never stops. Software cannot see or load the count. The block watches one tap bit of the counter, bit 12 by default. Each time that bit changes, in either direction, the block latches an interrupt pending flag, so an event occurs once every 4096 ticks.

A two-bit control/status port lets software read the pending flag and the enable bit, clear the flag, and set or clear the enable. The interrupt output is the AND of the pending flag and the enable bit. Each tap toggle also produces a one-cycle wakeup strobe, whether or not the interrupt is enabled, for use by a low-power idle controller. A terminal strobe marks every wrap of the counter through zero, for a watchdog or a start-up delay counter.

The counter holds no meaningful value at power-up. For simulation it is loaded with a parameter value at reset. Only the spacing between events is part of the contract.

Top module: `idle_tmr`

## Requirements
- R1: The counter decrements by one on every clock edge where `tick_i` is high, and holds otherwise. It wraps from 0 to all ones, and `tap_o` pulses for one cycle, in the cycle after the edge on which the counter left 0. Consecutive `tap_o` pulses are 65536 ticks apart.
- R2: An event occurs on each tick edge where counter bit `TAP_BIT` (12 by default) changes value. Consecutive events are exactly 4096 ticks apart.
- R3: An event sets the pending flag, read at `csr_rdata_o[0]`, visible from the cycle after the event edge.
- R4: The pending flag stays set until a write with `csr_we_i` high and `csr_wdata_i[0]` low clears it. Writing 1 to bit 0 has no effect on the flag.
- R5: A write loads `csr_wdata_i[1]` into the enable bit, read at `csr_rdata_o[1]`. `irq_o` is high exactly when the pending flag and the enable bit are both set.
- R6: When a clear write and an event fall on the same edge, the pending flag is set after that edge.
- R7: `wake_o` is high for one cycle after each event edge, regardless of the enable bit.
- R8: `tap_o` and `wake_o` are never high in two consecutive cycles.
- R9: After reset, the pending flag, the enable bit, `irq_o`, `wake_o` and `tap_o` are low. The counter holds `RST_VAL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Instruction-cycle enable; the counter advances on edges where it is high |
| csr_we_i | input | 1 | Control write strobe |
| csr_wdata_i | input | 2 | Write data: bit 0 = 0 clears pending, bit 1 = enable |
| csr_rdata_o | output | 2 | Read data: bit 0 pending, bit 1 enable |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | One-cycle strobe on each tap toggle |
| tap_o | output | 1 | One-cycle strobe on each counter wrap |

## Verification
The assertions assume `tick_i` and `csr_we_i` are clean, synchronous levels with no X after reset, and that `TAP_BIT` is at least 1. The one-cycle strobe properties depend on that lower bound, because two events are then at least two ticks apart. The stimulus changes inputs only at the falling edge and draws ticks from runs that are continuous, sparse and random. It also holds a clear write on every cycle across several events to force the collision of R6. The run is long enough to pass through several full counter wraps.

// File: rtl/idle_tmr_pkg.sv
package idle_tmr_pkg;
  localparam int unsigned CSR_W    = 2;
  localparam int unsigned PEND_IDX = 0;
  localparam int unsigned EN_IDX   = 1;
endpackage

// File: rtl/idle_tmr_cnt.sv
module idle_tmr_cnt #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned TAP_BIT = 12,
  parameter logic [CNT_W-1:0] RST_VAL = '1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic toggle_o,
  output logic wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_dec;

  assign cnt_dec = cnt_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= RST_VAL;
    else if (tick_i) cnt_q <= cnt_dec;
  end

  // tap bit flips exactly when the decrement borrows into it
  assign toggle_o = tick_i & (cnt_q[TAP_BIT] ^ cnt_dec[TAP_BIT]);
  assign wrap_o   = tick_i & (cnt_q == '0);
endmodule

// File: rtl/idle_tmr_strobe.sv
module idle_tmr_strobe #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] pulse_o
);
  for (genvar g = 0; g < N; g++) begin : g_stb
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= evt_i[g];
    end
    assign pulse_o[g] = q;
  end
endmodule

// File: rtl/idle_tmr_csr.sv
module idle_tmr_csr
  import idle_tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             we_i,
  input  logic [CSR_W-1:0] wdata_i,
  output logic [CSR_W-1:0] rdata_o,
  output logic             irq_o
);
  logic pend_q, en_q, pend_d, en_d;

  always_comb begin
    pend_d = pend_q;
    if (we_i && !wdata_i[PEND_IDX]) pend_d = 1'b0;
    if (evt_i)                      pend_d = 1'b1; // event beats clear
    en_d = we_i ? wdata_i[EN_IDX] : en_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
    end
  end

  always_comb begin
    rdata_o           = '0;
    rdata_o[PEND_IDX] = pend_q;
    rdata_o[EN_IDX]   = en_q;
  end

  assign irq_o = pend_q & en_q;
endmodule

// File: rtl/idle_tmr.sv
module idle_tmr
  import idle_tmr_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned TAP_BIT = 12,
  parameter logic [CNT_W-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             csr_we_i,
  input  logic [CSR_W-1:0] csr_wdata_i,
  output logic [CSR_W-1:0] csr_rdata_o,
  output logic             irq_o,
  output logic             wake_o,
  output logic             tap_o
);
  logic toggle, wrap;
  logic [1:0] stb;

  idle_tmr_cnt #(.CNT_W(CNT_W), .TAP_BIT(TAP_BIT), .RST_VAL(RST_VAL)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .toggle_o(toggle), .wrap_o(wrap)
  );

  idle_tmr_csr u_csr (
    .clk_i, .rst_ni, .evt_i(toggle), .we_i(csr_we_i), .wdata_i(csr_wdata_i),
    .rdata_o(csr_rdata_o), .irq_o
  );

  idle_tmr_strobe #(.N(2)) u_stb (
    .clk_i, .rst_ni, .evt_i({wrap, toggle}), .pulse_o(stb)
  );

  assign wake_o = stb[0];
  assign tap_o  = stb[1];
endmodule

// File: rtl/idle_tmr_chk.sv
module idle_tmr_chk
  import idle_tmr_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             csr_we_i,
  input logic [CSR_W-1:0] csr_wdata_i,
  input logic [CSR_W-1:0] csr_rdata_o,
  input logic             irq_o,
  input logic             wake_o,
  input logic             tap_o
);
  AST_WAKE_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(tick_i)); // R2
  AST_WAKE_SETS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> csr_rdata_o[PEND_IDX]); // R3
  AST_PEND_FALL_BY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(csr_rdata_o[PEND_IDX]) |-> $past(csr_we_i && !csr_wdata_i[PEND_IDX])); // R4
  AST_IRQ_BOTH_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (csr_rdata_o[PEND_IDX] && csr_rdata_o[EN_IDX])); // R5
  AST_WAKE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o); // R8
  AST_TAP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_o |=> !tap_o); // R8
endmodule

bind idle_tmr idle_tmr_chk u_chk (.*);

// File: tb/idle_tmr_tb.sv
module idle_tmr_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       csr_we_i = 1'b0;
  logic [1:0] csr_wdata_i = 2'b00;
  logic [1:0] csr_rdata_o;
  logic       irq_o, wake_o, tap_o;

  int checks = 0, failures = 0;
  int v = 16'hFFFF;
  bit m_pend = 0, m_en = 0, m_wake = 0, m_tap = 0;
  longint ticks = 0, last_wake = -1, last_tap = -1;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  idle_tmr u_dut (.*);

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit t, bit we, logic [1:0] wd);
    bit ev, tp;
    int nv;
    tick_i = t; csr_we_i = we; csr_wdata_i = wd;
    @(posedge clk_i);
    nv = (v - 1) & 16'hFFFF;
    ev = t && (((nv >> 12) & 1) != ((v >> 12) & 1));
    tp = t && (v == 0);
    if (t) begin v = nv; ticks++; end
    if (we && !wd[0]) m_pend = 0;
    if (ev) m_pend = 1;               // R6 event wins
    if (we) m_en = wd[1];
    m_wake = ev; m_tap = tp;
    @(negedge clk_i);
    chk("R3/R4/R6 pend", csr_rdata_o[0], m_pend);
    chk("R5 en", csr_rdata_o[1], m_en);
    chk("R5 irq", irq_o, m_pend && m_en);
    chk("R7 wake", wake_o, m_wake);
    chk("R1 tap", tap_o, m_tap);
    if (wake_o) begin
      if (last_wake >= 0) chk("R2 spacing", ticks - last_wake, 4096);
      last_wake = ticks;
    end
    if (tap_o) begin
      if (last_tap >= 0) chk("R1 wrap spacing", ticks - last_tap, 65536);
      last_tap = ticks;
    end
  endtask

  initial begin
    #1000000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R9 pend", csr_rdata_o[0], 0);
    chk("R9 en", csr_rdata_o[1], 0);
    chk("R9 irq", irq_o, 0);
    chk("R9 wake", wake_o, 0);
    chk("R9 tap", tap_o, 0);
    // disabled: pending sets, irq stays low, wake still strobes (R7)
    for (int i = 0; i < 5000; i++) step(1, 0, 2'b00);
    chk("R3 pend after event", csr_rdata_o[0], 1);
    chk("R5 irq masked", irq_o, 0);
    // writing 1 to pending bit must not clear (R4)
    step(0, 1, 2'b11);
    chk("R4 write1 keeps", csr_rdata_o[0], 1);
    chk("R5 irq enabled", irq_o, 1);
    step(0, 1, 2'b10);
    chk("R4 clear", csr_rdata_o[0], 0);
    // sparse ticks, random writes
    for (int i = 0; i < 20000; i++)
      step(($urandom % 3) == 0, ($urandom % 50) == 0, 2'($urandom));
    // clear every cycle across events: collision (R6)
    for (int i = 0; i < 9000; i++) step(1, 1, 2'b10);
    // long continuous run through wraps (R1)
    for (int i = 0; i < 140000; i++) step(1, ($urandom % 200) == 0, 2'($urandom));
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule